// File: doc/BRIEF.md
# Exit Register Store List Walker

On an exit event, this block saves a list of register values into a local table of 128-bit entries. After a start strobe it works through the table one entry at a time, from entry 0 up to a programmed count. It takes the 32-bit register index from the low word of each entry and fetches that register through a request/response read port. The 64-bit value that comes back is written into the upper half of the same entry (bits 127:64).

Each entry is checked before anything is stored. Bits 63:32 of the entry must be zero. The register read port also returns three flags with the data: a fault flag, a flag saying the register may be read only in system-management mode, and a flag saying the register is barred from being saved. If the exit does not end in system-management mode, the mode-only flag counts as a failure. The first entry that fails ends the whole walk. The block then raises `abort`, reports the position of the failing entry, and does not touch the table or the read port again.

The table port reads the lower half of an entry (bits 63:0) with a latency of one cycle. It writes the upper half (bits 127:64) of an entry on its own strobe.

Top module: `exit_store_walker`

## Requirements
- R1: Entries are visited strictly in ascending order from position 0. Each position is read once, and no position at or above the count latched at start is touched.
- R2: The register index sent on `reg_idx` is bits 31:0 of the entry. The 64-bit response data is written to bits 127:64 of the same entry position. Bits 63:0 are never written.
- R3: An entry whose bits 63:32 are not all zero fails. No register request is issued for it.
- R4: A response with `reg_rsp_smm_only`=1 fails when `exit_to_smm`=0. It is stored normally when `exit_to_smm`=1.
- R5: A response with `reg_rsp_blocked`=1 or `reg_rsp_fault`=1 fails, whatever the value of `exit_to_smm`.
- R6: On the first failure the walk ends. `done` and `abort` rise together, and `abort_entry` gives the failing position. The failing entry's upper half is not written.
- R7: After a failure, no later entry is read or written and no further register request is made.
- R8: A start with count 0 raises `done` in the cycle after start, with `abort`=0 and no table or register access.
- R9: A start strobe while `busy`=1 is ignored. The running walk finishes with its original count and its results are unchanged.
- R10: `done` is a single-cycle pulse. `abort` and `abort_entry` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| entry_count | input | ADDR_W+1 | Number of entries to walk, up to 2**ADDR_W |
| exit_to_smm | input | 1 | The exit ends in system-management mode |
| mem_rd_en | output | 1 | Table read strobe |
| mem_wr_en | output | 1 | Table upper-half write strobe |
| mem_addr | output | ADDR_W | Table entry position |
| mem_rdata | input | 64 | Entry bits 63:0, valid one cycle after `mem_rd_en` |
| mem_wdata | output | 64 | Value for entry bits 127:64 |
| reg_req | output | 1 | Register read request, single cycle |
| reg_idx | output | 32 | Register index of the request |
| reg_rsp_valid | input | 1 | Response strobe |
| reg_rsp_data | input | 64 | Register value |
| reg_rsp_fault | input | 1 | Reading at the highest privilege would fault |
| reg_rsp_smm_only | input | 1 | Register is readable only in system-management mode |
| reg_rsp_blocked | input | 1 | Register is barred from being saved |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| abort | output | 1 | The last walk ended on a failing entry |
| abort_entry | output | ADDR_W | Position of the failing entry |

## Verification
Random walks mix clean entries with three kinds of bad entry: entries with nonzero reserved bits, entries whose response carries the mode-only flag (run with both settings of `exit_to_smm`), and entries whose response carries the blocked or fault flag. The register port answers with a random latency. Comparing the whole table after each walk shows both which entries were stored and which were left untouched after the first failure. Directed walks cover a zero count, a full table, a failure at the first and at the last position, and a start pulse in the middle of a walk. Telling the ignored-start case apart from a restart depends on the count that was actually walked.

// File: rtl/esw_pkg.sv
package esw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_MEMW, S_CHK, S_REQ, S_WAIT, S_WR, S_FIN
  } esw_state_t;

  // Reserved upper word of the entry's lower half must be clear
  function automatic logic resv_clear(input logic [63:0] lo);
    return lo[63:32] == 32'd0;
  endfunction

  // Response-based failure decision
  function automatic logic store_fault(input logic fault, input logic smm_only,
                                       input logic blocked, input logic to_smm);
    return fault | blocked | (smm_only & ~to_smm);
  endfunction

  function automatic logic [31:0] index_of(input logic [63:0] lo);
    return lo[31:0];
  endfunction

endpackage

// File: rtl/esw_entry_check.sv
module esw_entry_check
  import esw_pkg::*;
(
  input  logic [63:0] entry_lo,
  input  logic        rsp_fault,
  input  logic        rsp_smm_only,
  input  logic        rsp_blocked,
  input  logic        to_smm,
  output logic        resv_bad,
  output logic        rsp_bad
);
  assign resv_bad = ~resv_clear(entry_lo);
  assign rsp_bad  = store_fault(rsp_fault, rsp_smm_only, rsp_blocked, to_smm);
endmodule

// File: rtl/esw_pos_ctr.sv
module esw_pos_ctr #(
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [CNT_W-1:0]  limit,
  output logic [ADDR_W-1:0] pos,
  output logic              last
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_nx;

  assign pos_nx = pos_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos_q <= '0;
    else if (clr) pos_q <= '0;
    else if (inc) pos_q <= pos_nx;
  end

  assign pos  = pos_q[ADDR_W-1:0];
  assign last = (pos_nx == limit);
endmodule

// File: rtl/exit_store_walker.sv
module exit_store_walker
  import esw_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  entry_count,
  input  logic              exit_to_smm,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [63:0]       mem_rdata,
  output logic [63:0]       mem_wdata,
  output logic              reg_req,
  output logic [31:0]       reg_idx,
  input  logic              reg_rsp_valid,
  input  logic [63:0]       reg_rsp_data,
  input  logic              reg_rsp_fault,
  input  logic              reg_rsp_smm_only,
  input  logic              reg_rsp_blocked,
  output logic              busy,
  output logic              done,
  output logic              abort,
  output logic [ADDR_W-1:0] abort_entry
);

  esw_state_t        st;
  logic [CNT_W-1:0]  cnt_q;
  logic [63:0]       entry_q;
  logic [63:0]       data_q;
  logic              abort_q;
  logic [ADDR_W-1:0] abort_pos_q;
  logic [ADDR_W-1:0] rd_pos_q;
  logic [ADDR_W-1:0] pos;
  logic              last;
  logic              resv_bad;
  logic              rsp_bad;

  // Named internal events
  logic start_acc;
  logic start_ign;
  logic resv_fail;
  logic rsp_take;
  logic rsp_fail;

  assign start_acc = start && (st == S_IDLE);
  assign start_ign = start && (st != S_IDLE);
  assign resv_fail = (st == S_CHK) && resv_bad;
  assign rsp_take  = (st == S_WAIT) && reg_rsp_valid;
  assign rsp_fail  = rsp_take && rsp_bad;

  esw_entry_check u_check (
    .entry_lo     (entry_q),
    .rsp_fault    (reg_rsp_fault),
    .rsp_smm_only (reg_rsp_smm_only),
    .rsp_blocked  (reg_rsp_blocked),
    .to_smm       (exit_to_smm),
    .resv_bad     (resv_bad),
    .rsp_bad      (rsp_bad)
  );

  esw_pos_ctr #(.ADDR_W(ADDR_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc),
    .inc   (st == S_WR),
    .limit (cnt_q),
    .pos   (pos),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt_q       <= '0;
      entry_q     <= '0;
      data_q      <= '0;
      abort_q     <= 1'b0;
      abort_pos_q <= '0;
      rd_pos_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_acc) begin
          cnt_q       <= entry_count;
          abort_q     <= 1'b0;
          abort_pos_q <= '0;
          st          <= (entry_count == '0) ? S_FIN : S_RD;
        end
        S_RD: begin
          rd_pos_q <= pos;
          st       <= S_MEMW;
        end
        S_MEMW: begin
          entry_q <= mem_rdata;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (resv_fail) begin
            abort_q     <= 1'b1;
            abort_pos_q <= pos;
            st          <= S_FIN;
          end else begin
            st <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rsp_take) begin
          if (rsp_fail) begin
            abort_q     <= 1'b1;
            abort_pos_q <= pos;
            st          <= S_FIN;
          end else begin
            data_q <= reg_rsp_data;
            st     <= S_WR;
          end
        end
        S_WR:  st <= last ? S_FIN : S_RD;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = (st == S_RD);
  assign mem_wr_en   = (st == S_WR);
  assign mem_addr    = pos;
  assign mem_wdata   = data_q;
  assign reg_req     = (st == S_REQ);
  assign reg_idx     = index_of(entry_q);
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign abort       = abort_q;
  assign abort_entry = abort_pos_q;

  AST_WR_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_addr == rd_pos_q); // R2
  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !rsp_fail) |=> (mem_wr_en && mem_wdata == $past(reg_rsp_data))); // R2
  AST_RESV_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> entry_q[63:32] == 32'd0); // R3
  AST_SMM_ONLY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && reg_rsp_smm_only && !exit_to_smm) |=> (abort && done)); // R4
  AST_BLOCKED_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && (reg_rsp_blocked || reg_rsp_fault)) |=> (abort && done)); // R5
  AST_FAIL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |=> !mem_wr_en); // R6
  AST_QUIET_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!mem_rd_en && !mem_wr_en && !reg_req)); // R7
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && entry_count == '0) |=> (done && !mem_rd_en && !abort)); // R8
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_ign |=> $stable(cnt_q)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start_acc) |=> (abort && $stable(abort_entry))); // R10

endmodule

// File: tb/exit_store_walker_test.sv
module exit_store_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW:0]   entry_count = '0;
  logic          exit_to_smm = 1'b0;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_rdata = '0;
  logic [63:0]   mem_wdata;
  logic          reg_req;
  logic [31:0]   reg_idx;
  logic          reg_rsp_valid = 1'b0;
  logic [63:0]   reg_rsp_data = '0;
  logic          reg_rsp_fault = 1'b0, reg_rsp_smm_only = 1'b0, reg_rsp_blocked = 1'b0;
  logic          busy, done, abort;
  logic [AW-1:0] abort_entry;

  exit_store_walker #(.ADDR_W(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Table model and register flags (keyed by index bits 3:0)
  logic [63:0] lo [N];
  logic [63:0] hi [N];
  logic [63:0] exp_hi [N];
  logic        f_smm [N];
  logic        f_blk [N];
  logic        f_err [N];

  int checks = 0, errors = 0;
  int accesses = 0, late_acc = 0, order_err = 0, rd_next = 0, fail_lim = N;
  int lat = 0;
  logic [31:0] pidx = '0;

  function automatic logic [63:0] regval(input logic [31:0] idx);
    return {idx ^ 32'h5A5A_0F0F, ~idx};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= lo[mem_addr];
      if (int'(mem_addr) != rd_next) order_err <= order_err + 1;
      rd_next <= rd_next + 1;
    end
    if (mem_wr_en) hi[mem_addr] <= mem_wdata;
    if (mem_rd_en || mem_wr_en || reg_req) accesses <= accesses + 1;
    if ((mem_rd_en || mem_wr_en) && int'(mem_addr) > fail_lim) late_acc <= late_acc + 1;
    reg_rsp_valid <= 1'b0;
    if (reg_req) begin
      lat  <= 1 + int'($urandom % 3);
      pidx <= reg_idx;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        reg_rsp_valid    <= 1'b1;
        reg_rsp_data     <= regval(pidx);
        reg_rsp_smm_only <= f_smm[pidx[3:0]];
        reg_rsp_blocked  <= f_blk[pidx[3:0]];
        reg_rsp_fault    <= f_err[pidx[3:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Build a table; kind per entry: 0 clean,1 reserved bits,2 smm-only,3 blocked,4 fault
  task automatic fill(input int pos, input int kind);
    lo[pos] = {32'd0, $urandom & 32'hFFFF_FFF0 | 32'(pos)};
    hi[pos] = {$urandom, $urandom};
    f_smm[pos] = (kind == 2);
    f_blk[pos] = (kind == 3);
    f_err[pos] = (kind == 4);
    if (kind == 1) lo[pos][63:32] = 32'h1 << ($urandom % 32);
  endtask

  task automatic run_walk(input int cnt, input bit to_smm, input bit poke, input string tag);
    int  fpos = -1;
    int  cyc = 0;
    int  acc0;
    for (int i = 0; i < N; i++) exp_hi[i] = hi[i];
    for (int i = 0; i < cnt; i++) begin
      if (lo[i][63:32] != 0 || f_blk[i] || f_err[i] || (f_smm[i] && !to_smm)) begin
        fpos = i;
        break;
      end
      exp_hi[i] = regval(lo[i][31:0]);
    end
    fail_lim = (fpos >= 0) ? fpos : N;
    rd_next = 0; late_acc = 0; order_err = 0;
    acc0 = accesses;
    exit_to_smm = to_smm;
    @(negedge clk);
    start = 1'b1; entry_count = (AW+1)'(cnt);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      if (poke && cyc == 2) begin
        start = 1'b1; entry_count = (AW+1)'(cnt == N ? 1 : cnt + 1);
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done, "R10", {tag, " walk completes"}, 64'(done), 64'd1);
    if (cnt == 0) begin
      chk(cyc == 0, "R8", {tag, " done cycle after start"}, 64'(cyc), 64'd0);
      chk(accesses == acc0, "R8", {tag, " no access"}, 64'(accesses - acc0), 64'd0);
    end
    chk(abort == (fpos >= 0), "R6", {tag, " abort flag"}, 64'(abort), 64'(fpos >= 0));
    if (fpos >= 0)
      chk(int'(abort_entry) == fpos, "R6", {tag, " abort position"}, 64'(abort_entry), 64'(fpos));
    for (int i = 0; i < N; i++)
      if (hi[i] !== exp_hi[i]) begin
        chk(1'b0, "R2", {tag, " stored value"}, hi[i], exp_hi[i]);
        break;
      end
    chk(late_acc == 0, "R7", {tag, " no access past failure"}, 64'(late_acc), 64'd0);
    chk(order_err == 0, "R1", {tag, " ascending order"}, 64'(order_err), 64'd0);
    @(negedge clk);
    chk(!done, "R10", {tag, " done single pulse"}, 64'(done), 64'd0);
    chk(abort == (fpos >= 0), "R10", {tag, " abort held"}, 64'(abort), 64'(fpos >= 0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < N; i++) fill(i, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !abort, "R10", "reset state", {61'd0, busy, done, abort}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: zero count
    run_walk(0, 1'b0, 1'b0, "zero");
    // R1/R2: full clean table
    for (int i = 0; i < N; i++) fill(i, 0);
    run_walk(N, 1'b0, 1'b0, "full");
    // R3: reserved bits at position 0
    for (int i = 0; i < N; i++) fill(i, 0);
    fill(0, 1);
    run_walk(8, 1'b0, 1'b0, "resv0");
    // R5: blocked at last position
    for (int i = 0; i < N; i++) fill(i, 0);
    fill(N-1, 3);
    run_walk(N, 1'b1, 1'b0, "blocked_last");
    // R4: smm-only passes when exit ends in that mode, fails otherwise
    for (int i = 0; i < N; i++) fill(i, 0);
    fill(3, 2);
    run_walk(6, 1'b1, 1'b0, "smm_ok");
    for (int i = 0; i < N; i++) fill(i, 0);
    fill(3, 2);
    run_walk(6, 1'b0, 1'b0, "smm_fail");
    // R5: fault flag
    for (int i = 0; i < N; i++) fill(i, 0);
    fill(5, 4);
    run_walk(10, 1'b1, 1'b0, "fault");
    // R9: start pulse during a walk
    for (int i = 0; i < N; i++) fill(i, 0);
    run_walk(5, 1'b0, 1'b1, "poke");

    // Random walks
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom % 20);
        fill(i, (r < 15) ? 0 : r - 15);
      end
      run_walk(int'($urandom % (N + 1)), 1'($urandom), 1'b0, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule